// File: doc/BRIEF.md
# Hold-Arbitrated Multiplexed Bus Master

This block sequences single-word transfers between a peripheral and a host processor over a shared, slow bus that carries address and data on the same lines. A receive event from the peripheral side starts a write transfer and raises an interrupt request to the host. A channel-attention pulse from the host withdraws that interrupt and starts a read transfer. In both cases the block raises HOLD, waits for the bus grant HLDA, runs a four-phase bus cycle (T1 to T4), and then gives the bus back.

In T1 the block drives the target address. In T2 a write puts its data word on the lines, while a read leaves them released. T3 lasts until READY is seen high, so the target can insert wait states. On a read, the word on the bus is captured at that same edge and shown with a one-cycle valid strobe. HOLD drops at the end of T4. The block returns to idle once the grant has been withdrawn.

Events that arrive while a transfer is in flight are held as pending. A pending read is served before a pending write, and only one transfer runs at a time. The address and data for each transfer are taken from input ports at the edge that launches it.

Top module: `mux_bus_master`

## Requirements
- R1: While rst_ni is low, and right after it rises, int_req_o, hold_o, ad_oe_o and rd_valid_o are low, and every pending request is cleared.
- R2: A receive event (rx_evt_i high at an edge while idle) sets int_req_o at that edge. hold_o rises at the next edge.
- R3: Channel attention (chan_attn_i high at an edge while idle) clears int_req_o at that edge. hold_o rises at the next edge.
- R4: While hold_o is high and hlda_i is low before T1, hold_o stays high, ad_oe_o stays low and no phase begins, for any number of cycles.
- R5: The first edge with hlda_i high in the hold-wait state enters T1. T1 lasts one cycle, during which ad_oe_o is high and ad_o carries the transfer address.
- R6: In a write, T2 lasts one cycle with ad_oe_o high and ad_o equal to the write data word. ad_oe_o is low from T3 until the next transfer's T1.
- R7: In T2 of a read, ad_oe_o is low. In T3 of either transfer type, ad_oe_o is low. T3 repeats while ready_i is low at the edge. At the first edge where ready_i is high, a read captures ad_i into rd_data_o and raises rd_valid_o for exactly the one T4 cycle. A write never raises rd_valid_o.
- R8: T4 lasts one cycle with hold_o high. hold_o is low from the next edge on. The block stays in that release state until an edge with hlda_i low, and after that edge it is idle.
- R9: ad_oe_o is high only while hlda_i is high and hold_o is high. Dropping hlda_i during T1 releases the bus immediately.
- R10: rx_evt_i and chan_attn_i pulses seen during a transfer are held as pending. When the block returns to idle, a pending read launches before a pending write. If both events arrive together while idle, the read launches and the write stays pending.
- R11: The address (rd_addr_i for a read, wr_addr_i for a write) and wr_data_i are sampled at the launch edge. Later changes to those inputs do not affect the transfer in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_evt_i | input | 1 | Receive event; requests a write transfer |
| chan_attn_i | input | 1 | Channel attention from host; requests a read transfer |
| hlda_i | input | 1 | Bus grant |
| ready_i | input | 1 | Target ready; low inserts wait states in T3 |
| wr_addr_i | input | W | Address for write transfers |
| wr_data_i | input | W | Data word for write transfers |
| rd_addr_i | input | W | Address for read transfers |
| ad_i | input | W | Sampled value of the multiplexed bus |
| int_req_o | output | 1 | Interrupt request to host |
| hold_o | output | 1 | Bus request |
| ad_o | output | W | Value driven on the multiplexed bus |
| ad_oe_o | output | 1 | Output enable for ad_o |
| rd_data_o | output | W | Last word captured by a read |
| rd_valid_o | output | 1 | One-cycle strobe for rd_data_o |

## Verification
The assertions assume a well-behaved arbiter and target. HLDA rises only while HOLD is high and falls after HOLD drops. READY is only meaningful during T3. Events are single-cycle pulses. The bench keeps to these rules: it raises the grant only after observing HOLD, removes it in the release cycle, and holds READY low everywhere except on the cycle that ends T3. The one exception is a deliberate grant drop inside T1. That drop is restored before the next edge, so the state sequence is never affected.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ANNOUNCE, S_HOLD, S_T1, S_T2, S_T3, S_T4, S_REL
  } mbm_state_e;
endpackage

// File: rtl/mbm_arb.sv
module mbm_arb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic idle_i,
  input  logic rx_evt_i,
  input  logic chan_attn_i,
  output logic launch_rd_o,
  output logic launch_wr_o,
  output logic int_req_o
);
  logic pend_rd_q, pend_wr_q;

  // reads take priority over writes
  always_comb begin
    launch_rd_o = idle_i & (chan_attn_i | pend_rd_q);
    launch_wr_o = idle_i & ~launch_rd_o & (rx_evt_i | pend_wr_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_rd_q <= 1'b0;
      pend_wr_q <= 1'b0;
      int_req_o <= 1'b0;
    end else begin
      pend_rd_q <= (pend_rd_q | chan_attn_i) & ~launch_rd_o;
      pend_wr_q <= (pend_wr_q | rx_evt_i) & ~launch_wr_o;
      if (launch_rd_o)      int_req_o <= 1'b0;
      else if (launch_wr_o) int_req_o <= 1'b1;
    end
  end

  a_r10_write_waits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_wr_q && !launch_wr_o) |=> pend_wr_q);
  a_r3_int_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_rd_o |=> !int_req_o);
endmodule

// File: rtl/mbm_seq.sv
module mbm_seq
  import mbm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       launch_rd_i,
  input  logic       launch_wr_i,
  input  logic       hlda_i,
  input  logic       ready_i,
  output mbm_state_e state_o,
  output logic       is_rd_o,
  output logic       idle_o,
  output logic       hold_o,
  output logic       capture_o
);
  mbm_state_e state_q, state_d;
  logic       rd_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:     if (launch_rd_i | launch_wr_i) state_d = S_ANNOUNCE;
      S_ANNOUNCE: state_d = S_HOLD;
      S_HOLD:     if (hlda_i) state_d = S_T1;
      S_T1:       state_d = S_T2;
      S_T2:       state_d = S_T3;
      S_T3:       if (ready_i) state_d = S_T4;
      S_T4:       state_d = S_REL;
      S_REL:      if (!hlda_i) state_d = S_IDLE;
      default:    state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      rd_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && (launch_rd_i | launch_wr_i)) rd_q <= launch_rd_i;
    end
  end

  assign state_o   = state_q;
  assign is_rd_o   = rd_q;
  assign idle_o    = (state_q == S_IDLE);
  assign hold_o    = (state_q == S_HOLD) || (state_q == S_T1) || (state_q == S_T2) ||
                     (state_q == S_T3)   || (state_q == S_T4);
  assign capture_o = (state_q == S_T3) && ready_i && rd_q;

  a_r2_hold_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ANNOUNCE) |=> hold_o);
  a_r4_wait_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_HOLD && !hlda_i) |=> (state_q == S_HOLD && hold_o));
  a_r5_t1_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_T1) |=> (state_q == S_T2));
  a_r7_wait_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_T3 && !ready_i) |=> (state_q == S_T3));
  a_r8_hold_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_T4) |=> !hold_o);
endmodule

// File: rtl/mbm_bus.sv
module mbm_bus
  import mbm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           launch_rd_i,
  input  logic           launch_wr_i,
  input  logic [W-1:0]   wr_addr_i,
  input  logic [W-1:0]   wr_data_i,
  input  logic [W-1:0]   rd_addr_i,
  input  mbm_state_e     state_i,
  input  logic           is_rd_i,
  input  logic           hlda_i,
  input  logic           capture_i,
  input  logic [W-1:0]   ad_i,
  output logic [W-1:0]   ad_o,
  output logic           ad_oe_o,
  output logic [W-1:0]   rd_data_o,
  output logic           rd_valid_o
);
  localparam logic [W-1:0] Zero = '0;

  logic [W-1:0] addr_q, data_q;
  logic         own_phase, data_phase;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q     <= Zero;
      data_q     <= Zero;
      rd_data_o  <= Zero;
      rd_valid_o <= 1'b0;
    end else begin
      if (launch_rd_i)      addr_q <= rd_addr_i;
      else if (launch_wr_i) begin
        addr_q <= wr_addr_i;
        data_q <= wr_data_i;
      end
      if (capture_i) rd_data_o <= ad_i;
      rd_valid_o <= capture_i;
    end
  end

  assign data_phase = (state_i == S_T2) && !is_rd_i;
  assign own_phase  = (state_i == S_T1) || data_phase;
  assign ad_oe_o    = hlda_i && own_phase;
  assign ad_o       = !ad_oe_o ? Zero : (data_phase ? data_q : addr_q);

  a_r7_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);
  a_r7_read_t2_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_T2 && is_rd_i) |-> !ad_oe_o);
endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rx_evt_i,
  input  logic         chan_attn_i,
  input  logic         hlda_i,
  input  logic         ready_i,
  input  logic [W-1:0] wr_addr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [W-1:0] rd_addr_i,
  input  logic [W-1:0] ad_i,
  output logic         int_req_o,
  output logic         hold_o,
  output logic [W-1:0] ad_o,
  output logic         ad_oe_o,
  output logic [W-1:0] rd_data_o,
  output logic         rd_valid_o
);
  import mbm_pkg::*;

  logic       launch_rd, launch_wr, idle, is_rd, capture;
  mbm_state_e state;

  mbm_arb u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .idle_i(idle),
    .rx_evt_i(rx_evt_i), .chan_attn_i(chan_attn_i),
    .launch_rd_o(launch_rd), .launch_wr_o(launch_wr), .int_req_o(int_req_o)
  );

  mbm_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .launch_rd_i(launch_rd), .launch_wr_i(launch_wr),
    .hlda_i(hlda_i), .ready_i(ready_i),
    .state_o(state), .is_rd_o(is_rd), .idle_o(idle),
    .hold_o(hold_o), .capture_o(capture)
  );

  mbm_bus #(.W(W)) u_bus (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .launch_rd_i(launch_rd), .launch_wr_i(launch_wr),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
    .state_i(state), .is_rd_i(is_rd), .hlda_i(hlda_i), .capture_i(capture),
    .ad_i(ad_i), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
  );

  a_r9_oe_within_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |-> (hold_o && hlda_i));
endmodule

// File: tb/mux_bus_master_test.sv
module mux_bus_master_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         rx_evt = 1'b0, chan_attn = 1'b0, hlda = 1'b0, ready = 1'b0;
  logic [W-1:0] wr_addr = '0, wr_data = '0, rd_addr = '0, ad_in = '0;
  logic         int_req, hold, ad_oe, rd_valid;
  logic [W-1:0] ad_out, rd_data;
  int           n_chk = 0, n_bad = 0;
  bit           done = 1'b0;

  always #5 clk = ~clk;

  mux_bus_master #(.W(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .rx_evt_i(rx_evt), .chan_attn_i(chan_attn),
    .hlda_i(hlda), .ready_i(ready), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .ad_i(ad_in), .int_req_o(int_req), .hold_o(hold),
    .ad_o(ad_out), .ad_oe_o(ad_oe), .rd_data_o(rd_data), .rd_valid_o(rd_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Starts at a negedge with the block idle; ends at a negedge with it idle again.
  task automatic run_xfer(input bit rd, input bit fire_rx, input bit fire_ca,
                          input bit side, input int busy, input int waits,
                          input bit drop_t1, input logic [W-1:0] seed);
    logic [W-1:0] a_exp, d_exp, r_word;
    a_exp  = rd ? seed : seed + 16'd1;
    d_exp  = seed ^ 16'hA5A5;
    r_word = seed * 16'd3 + 16'd7;
    rd_addr = seed; wr_addr = seed + 16'd1; wr_data = d_exp;
    rx_evt = fire_rx; chan_attn = fire_ca;
    @(negedge clk);                                      // launch edge passed
    rx_evt = 1'b0; chan_attn = 1'b0;
    rd_addr = ~seed; wr_addr = ~seed; wr_data = ~d_exp;  // R11: must not matter
    chk(rd ? "R3 int cleared" : "R2 int raised", int_req, rd ? 0 : 1);
    chk("R2 R3 hold not yet", hold, 0);
    @(negedge clk);
    chk("R2 R3 hold raised", hold, 1);
    chk("R4 no drive before grant", ad_oe, 0);
    if (side) begin rx_evt = 1'b1; chan_attn = 1'b1; end
    for (int i = 0; i < busy; i++) begin
      @(negedge clk);
      rx_evt = 1'b0; chan_attn = 1'b0;
      chk("R4 hold kept", hold, 1);
      chk("R4 no drive while busy", ad_oe, 0);
    end
    hlda = 1'b1;
    @(negedge clk);                                      // T1
    rx_evt = 1'b0; chan_attn = 1'b0;
    chk("R5 T1 enable", ad_oe, 1);
    chk("R5 R11 T1 address", ad_out, a_exp);
    if (drop_t1) begin
      hlda = 1'b0; #1;
      chk("R9 grant loss releases bus", ad_oe, 0);
      hlda = 1'b1;
    end
    @(negedge clk);                                      // T2
    if (rd) chk("R7 read T2 released", ad_oe, 0);
    else begin
      chk("R6 write T2 enable", ad_oe, 1);
      chk("R6 R11 write data", ad_out, d_exp);
    end
    ad_in = r_word;
    @(negedge clk);                                      // T3
    chk("R6 R7 T3 released", ad_oe, 0);
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      chk("R7 wait state hold", hold, 1);
      chk("R7 wait state no strobe", rd_valid, 0);
      chk("R7 wait state released", ad_oe, 0);
    end
    ready = 1'b1;
    @(negedge clk);                                      // T4
    ready = 1'b0;
    ad_in = ~r_word;
    chk("R7 strobe in T4", rd_valid, rd);
    if (rd) chk("R7 captured word", rd_data, r_word);
    chk("R8 hold in T4", hold, 1);
    @(negedge clk);                                      // release
    chk("R8 hold dropped", hold, 0);
    chk("R7 strobe single", rd_valid, 0);
    chk("R9 no drive after T4", ad_oe, 0);
    if (rd) chk("R7 data held", rd_data, r_word);
    hlda = 1'b0;
    @(negedge clk);                                      // idle
    chk("R8 idle no hold", hold, 0);
    chk(rd ? "R3 int stays low" : "R2 int stays high", int_req, rd ? 0 : 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset int", int_req, 0);
    chk("R1 reset hold", hold, 0);
    chk("R1 reset oe", ad_oe, 0);
    chk("R1 reset strobe", rd_valid, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after reset hold", hold, 0);

    for (int rd = 0; rd < 2; rd++)
      for (int busy = 0; busy < 3; busy++)
        for (int waits = 0; waits < 4; waits++)
          run_xfer(rd[0], !rd[0], rd[0], 1'b0, busy, waits, (busy == 1 && waits == 0),
                   16'(rd * 4099 + busy * 613 + waits * 71 + 5));

    // R10: both pulses arrive mid-transfer; read drains first, then write
    run_xfer(1'b0, 1'b1, 1'b0, 1'b1, 2, 1, 1'b0, 16'h1234);
    run_xfer(1'b1, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0, 16'h2345);
    run_xfer(1'b0, 1'b0, 1'b0, 1'b0, 1, 2, 1'b0, 16'h3456);
    repeat (2) @(negedge clk);
    chk("R10 queue empty", hold, 0);

    // R10: simultaneous while idle -> read now, write next
    run_xfer(1'b1, 1'b1, 1'b1, 1'b0, 1, 0, 1'b0, 16'h4567);
    run_xfer(1'b0, 1'b0, 1'b0, 1'b0, 0, 1, 1'b0, 16'h5678);
    @(negedge clk);
    chk("R10 queue empty after pair", hold, 0);

    // R1: reset mid-transfer clears state and pending work
    rx_evt = 1'b1;
    @(negedge clk); rx_evt = 1'b0; chan_attn = 1'b1;
    @(negedge clk); chan_attn = 1'b0;
    chk("R2 hold before reset", hold, 1);
    rst_ni = 1'b0; #1;
    chk("R1 async hold clear", hold, 0);
    chk("R1 async int clear", int_req, 0);
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 pending cleared", hold, 0);
    chk("R1 int stays low", int_req, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule